// File: doc/BRIEF.md
# Retired-Stream Trace Line Builder

This unit sits behind the retirement stage of a processor and packs the stream of retired instructions into trace lines for a trace cache. Each retired beat brings a program counter, the instruction word, a 3-bit kind code and, for branches, the resolved direction and target. The unit collects beats in program order until one of its stop rules fires. It then presents the finished line on a single write port toward the trace cache array. With the line come its control fields: the first PC, a packed record of branch directions, the branch count, an ends-in-branch bit, the fall-through address and the taken target.

The builder is armed by a trace-cache lookup miss. From then on it skips retired beats until the missed PC retires, and that beat opens a new line. After each finished line it keeps building: the next retired beat opens the following line. A pipeline flush throws away the partial line and disarms the builder until the next miss. Storage, replacement, decode and prediction belong to other units.

Top module: `trace_builder`

## Requirements
- R1: A line is finished by the beat that makes it hold MAX_INSNS (default 16) instructions.
- R2: Kind codes 1 (conditional), 2 (direct jump), 3 (return) and 4 (indirect) are branches, and each branch closes a basic block. A line is finished by the branch that brings its branch count to MAX_BLOCKS (default 3).
- R3: A line is finished right after a return (kind 3), an indirect branch (kind 4) or a system call (kind 5). A system call is not counted as a branch. Kind 0 is a plain instruction, and codes 6 and 7 act as plain.
- R4: lineStartPc is the PC of the line's first instruction. lineLength is its instruction count. Slot i of lineInsns (bits i*INSN_W upward) holds the i-th instruction word, for i below lineLength.
- R5: Bit i of lineFlags (i from 0 to MAX_BLOCKS-2) holds the direction of the line's i-th branch, in order: 1 = taken, 0 = not taken. A conditional branch uses inTaken, and other branches read as taken. Bits for branches that did not occur are 0.
- R6: lineBranchCount is the number of branches in the line. lineEndsBranch is 1 exactly when the last instruction is a branch.
- R7: lineFallThrough is the last instruction's PC plus INSN_BYTES (default 4). lineTarget is the inTarget of the last branch in the line, or 0 when the line has no branch.
- R8: After reset the builder is idle and ignores beats. A miss (missValid) discards any partial line and skips beats until one with inPc equal to missPc, which becomes the first instruction. A beat in the same cycle as a miss is ignored.
- R9: flush discards a partial line without emitting it and returns the builder to idle. A beat in the same cycle is ignored. If a miss arrives in the same cycle, the miss takes effect.
- R10: lineValid is high for exactly the one cycle after the finishing beat's clock edge. The next accepted beat, including one in that same cycle, opens a new line, so back-to-back finishing beats give back-to-back pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Retired beat present |
| inPc | input | PC_W | PC of the retired instruction |
| inInsn | input | INSN_W | Instruction word |
| inKind | input | 3 | Kind code (R2, R3) |
| inTaken | input | 1 | Resolved direction of a conditional branch |
| inTarget | input | PC_W | Resolved taken target of a branch |
| missValid | input | 1 | Trace-cache lookup missed |
| missPc | input | PC_W | PC that missed |
| flush | input | 1 | Pipeline flush |
| lineValid | output | 1 | One-cycle write strobe for a finished line |
| lineStartPc | output | PC_W | First PC of the line |
| lineLength | output | $clog2(MAX_INSNS+1) | Instruction count |
| lineFlags | output | MAX_BLOCKS-1 | Branch direction record |
| lineBranchCount | output | $clog2(MAX_BLOCKS+1) | Number of branches |
| lineEndsBranch | output | 1 | Last instruction is a branch |
| lineFallThrough | output | PC_W | Address after the last instruction |
| lineTarget | output | PC_W | Taken target of the last branch |
| lineInsns | output | MAX_INSNS*INSN_W | Instruction words, slot 0 lowest |

## Verification
A corrupted slot counter or branch counter shows up on the very next finished line. It appears as a wrong lineLength or a pulse that comes one beat early or late, and it also shifts every slot of lineInsns after the fault. A wrong armed or idle state shows up as a line starting at the wrong PC or as a pulse that should not exist, within the first beat after a miss or flush. Stale direction or target state shows up only on a line whose own branches do not overwrite it, so the stimulus includes lines without branches and lines with fewer than MAX_BLOCKS-1 branches.

// File: rtl/trace_builder_pkg.sv
package trace_builder_pkg;

  localparam logic [2:0] KIND_PLAIN    = 3'd0;
  localparam logic [2:0] KIND_COND     = 3'd1;
  localparam logic [2:0] KIND_JUMP     = 3'd2;
  localparam logic [2:0] KIND_RETURN   = 3'd3;
  localparam logic [2:0] KIND_INDIRECT = 3'd4;
  localparam logic [2:0] KIND_SYSCALL  = 3'd5;

  // Strobes from control to datapath, one set per cycle.
  typedef struct packed {
    logic accept;   // beat joins the current line
    logic start;    // beat is the first of a line
    logic finish;   // beat closes the line
    logic drop;     // discard the partial line
  } strobeT;

  function automatic logic isBranchKind(input logic [2:0] kind);
    return (kind == KIND_COND) || (kind == KIND_JUMP) ||
           (kind == KIND_RETURN) || (kind == KIND_INDIRECT);
  endfunction

  function automatic logic isStopKind(input logic [2:0] kind);
    return (kind == KIND_RETURN) || (kind == KIND_INDIRECT) ||
           (kind == KIND_SYSCALL);
  endfunction

endpackage

// File: rtl/trace_builder_ctrl.sv
module trace_builder_ctrl
  import trace_builder_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int MAX_INSNS  = 16,
  parameter int MAX_BLOCKS = 3,
  localparam int CNT_W = $clog2(MAX_INSNS + 1),
  localparam int BR_W  = $clog2(MAX_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [PC_W-1:0]  inPc,
  input  logic [2:0]       inKind,
  input  logic             missValid,
  input  logic [PC_W-1:0]  missPc,
  input  logic             flush,
  input  logic [CNT_W-1:0] instCount,
  input  logic [BR_W-1:0]  branchCount,
  output strobeT           strobes
);

  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_BUILD} stateT;

  stateT           state;
  logic [PC_W-1:0] huntPc;
  logic            hit;
  logic            lastSlot;
  logic            lastBlock;

  always_comb begin
    hit = inValid && !flush && !missValid &&
          (((state == ST_HUNT) && (inPc == huntPc)) || (state == ST_BUILD));
    lastSlot  = (instCount == CNT_W'(MAX_INSNS - 1));
    lastBlock = isBranchKind(inKind) && (branchCount == BR_W'(MAX_BLOCKS - 1));
    strobes.accept = hit;
    strobes.start  = hit && (instCount == '0);
    strobes.finish = hit && (lastSlot || lastBlock || isStopKind(inKind));
    strobes.drop   = flush || missValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      huntPc <= '0;
    end else if (missValid) begin
      state  <= ST_HUNT;
      huntPc <= missPc;
    end else if (flush) begin
      state  <= ST_IDLE;
    end else if (hit && (state == ST_HUNT)) begin
      state  <= ST_BUILD;
    end
  end

  AST_FINISH_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> (instCount == '0));  // R10

endmodule

// File: rtl/trace_builder_datapath.sv
module trace_builder_datapath
  import trace_builder_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INSN_W     = 32,
  parameter int MAX_INSNS  = 16,
  parameter int MAX_BLOCKS = 3,
  parameter int INSN_BYTES = 4,
  localparam int CNT_W  = $clog2(MAX_INSNS + 1),
  localparam int BR_W   = $clog2(MAX_BLOCKS + 1),
  localparam int FLAG_W = MAX_BLOCKS - 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobeT                      strobes,
  input  logic [PC_W-1:0]             inPc,
  input  logic [INSN_W-1:0]           inInsn,
  input  logic [2:0]                  inKind,
  input  logic                        inTaken,
  input  logic [PC_W-1:0]             inTarget,
  output logic [CNT_W-1:0]            instCount,
  output logic [BR_W-1:0]             branchCount,
  output logic                        lineValid,
  output logic [PC_W-1:0]             lineStartPc,
  output logic [CNT_W-1:0]            lineLength,
  output logic [FLAG_W-1:0]           lineFlags,
  output logic [BR_W-1:0]             lineBranchCount,
  output logic                        lineEndsBranch,
  output logic [PC_W-1:0]             lineFallThrough,
  output logic [PC_W-1:0]             lineTarget,
  output logic [MAX_INSNS*INSN_W-1:0] lineInsns
);

  logic [MAX_INSNS-1:0][INSN_W-1:0] buffer;
  logic [FLAG_W-1:0] flagsReg;
  logic [PC_W-1:0]   startPcReg;
  logic [PC_W-1:0]   targetReg;

  logic              brNow;
  logic              outcome;
  logic [FLAG_W-1:0] nxtFlags;
  logic [BR_W-1:0]   nxtBr;
  logic [CNT_W-1:0]  nxtCnt;
  logic [PC_W-1:0]   nxtTarget;
  logic [PC_W-1:0]   curStart;

  always_comb begin
    brNow    = isBranchKind(inKind);
    outcome  = (inKind == KIND_COND) ? inTaken : 1'b1;
    nxtFlags = flagsReg;
    for (int i = 0; i < FLAG_W; i++) begin
      if (brNow && (branchCount == BR_W'(i))) nxtFlags[i] = outcome;
    end
    nxtBr     = branchCount + BR_W'(brNow);
    nxtCnt    = instCount + CNT_W'(1);
    nxtTarget = brNow ? inTarget : targetReg;
    curStart  = strobes.start ? inPc : startPcReg;
  end

  // One write-enabled register per instruction slot.
  for (genvar g = 0; g < MAX_INSNS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) buffer[g] <= '0;
      else if (strobes.accept && (instCount == CNT_W'(g))) buffer[g] <= inInsn;
    end
  end

  assign lineInsns = buffer;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instCount       <= '0;
      branchCount     <= '0;
      flagsReg        <= '0;
      startPcReg      <= '0;
      targetReg       <= '0;
      lineValid       <= 1'b0;
      lineStartPc     <= '0;
      lineLength      <= '0;
      lineFlags       <= '0;
      lineBranchCount <= '0;
      lineEndsBranch  <= 1'b0;
      lineFallThrough <= '0;
      lineTarget      <= '0;
    end else begin
      lineValid <= 1'b0;
      if (strobes.drop) begin
        instCount   <= '0;
        branchCount <= '0;
        flagsReg    <= '0;
        targetReg   <= '0;
      end else if (strobes.accept) begin
        if (strobes.finish) begin
          lineValid       <= 1'b1;
          lineStartPc     <= curStart;
          lineLength      <= nxtCnt;
          lineFlags       <= nxtFlags;
          lineBranchCount <= nxtBr;
          lineEndsBranch  <= brNow;
          lineFallThrough <= inPc + PC_W'(INSN_BYTES);
          lineTarget      <= nxtTarget;
          instCount       <= '0;
          branchCount     <= '0;
          flagsReg        <= '0;
          targetReg       <= '0;
        end else begin
          instCount   <= nxtCnt;
          branchCount <= nxtBr;
          flagsReg    <= nxtFlags;
          targetReg   <= nxtTarget;
          startPcReg  <= curStart;
        end
      end
    end
  end

  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    instCount < CNT_W'(MAX_INSNS));  // R1
  AST_BLOCK_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    branchCount < BR_W'(MAX_BLOCKS));  // R2
  AST_STOP_FINISHES: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accept && isStopKind(inKind)) |-> strobes.finish);  // R3
  AST_LINE_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> (lineLength != '0));  // R4
  AST_DROP_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.drop |=> ((instCount == '0) && !lineValid));  // R9

endmodule

// File: rtl/trace_builder.sv
module trace_builder
  import trace_builder_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INSN_W     = 32,
  parameter int MAX_INSNS  = 16,
  parameter int MAX_BLOCKS = 3,
  parameter int INSN_BYTES = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                inValid,
  input  logic [PC_W-1:0]                     inPc,
  input  logic [INSN_W-1:0]                   inInsn,
  input  logic [2:0]                          inKind,
  input  logic                                inTaken,
  input  logic [PC_W-1:0]                     inTarget,
  input  logic                                missValid,
  input  logic [PC_W-1:0]                     missPc,
  input  logic                                flush,
  output logic                                lineValid,
  output logic [PC_W-1:0]                     lineStartPc,
  output logic [$clog2(MAX_INSNS+1)-1:0]      lineLength,
  output logic [MAX_BLOCKS-2:0]               lineFlags,
  output logic [$clog2(MAX_BLOCKS+1)-1:0]     lineBranchCount,
  output logic                                lineEndsBranch,
  output logic [PC_W-1:0]                     lineFallThrough,
  output logic [PC_W-1:0]                     lineTarget,
  output logic [MAX_INSNS*INSN_W-1:0]         lineInsns
);

  localparam int CNT_W = $clog2(MAX_INSNS + 1);
  localparam int BR_W  = $clog2(MAX_BLOCKS + 1);

  strobeT           strobes;
  logic [CNT_W-1:0] instCount;
  logic [BR_W-1:0]  branchCount;

  trace_builder_ctrl #(
    .PC_W(PC_W), .MAX_INSNS(MAX_INSNS), .MAX_BLOCKS(MAX_BLOCKS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPc(inPc), .inKind(inKind),
    .missValid(missValid), .missPc(missPc), .flush(flush),
    .instCount(instCount), .branchCount(branchCount), .strobes(strobes)
  );

  trace_builder_datapath #(
    .PC_W(PC_W), .INSN_W(INSN_W), .MAX_INSNS(MAX_INSNS),
    .MAX_BLOCKS(MAX_BLOCKS), .INSN_BYTES(INSN_BYTES)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inPc(inPc), .inInsn(inInsn),
    .inKind(inKind), .inTaken(inTaken), .inTarget(inTarget),
    .instCount(instCount), .branchCount(branchCount),
    .lineValid(lineValid), .lineStartPc(lineStartPc), .lineLength(lineLength),
    .lineFlags(lineFlags), .lineBranchCount(lineBranchCount),
    .lineEndsBranch(lineEndsBranch), .lineFallThrough(lineFallThrough),
    .lineTarget(lineTarget), .lineInsns(lineInsns)
  );

endmodule

// File: tb/trace_builder_test.sv
`timescale 1ns/100ps
module trace_builder_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [31:0]  inPc = '0;
  logic [31:0]  inInsn = '0;
  logic [2:0]   inKind = '0;
  logic         inTaken = 1'b0;
  logic [31:0]  inTarget = '0;
  logic         missValid = 1'b0;
  logic [31:0]  missPc = '0;
  logic         flush = 1'b0;
  logic         lineValid;
  logic [31:0]  lineStartPc;
  logic [4:0]   lineLength;
  logic [1:0]   lineFlags;
  logic [1:0]   lineBranchCount;
  logic         lineEndsBranch;
  logic [31:0]  lineFallThrough;
  logic [31:0]  lineTarget;
  logic [511:0] lineInsns;

  trace_builder uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPc(inPc), .inInsn(inInsn),
    .inKind(inKind), .inTaken(inTaken), .inTarget(inTarget),
    .missValid(missValid), .missPc(missPc), .flush(flush),
    .lineValid(lineValid), .lineStartPc(lineStartPc), .lineLength(lineLength),
    .lineFlags(lineFlags), .lineBranchCount(lineBranchCount),
    .lineEndsBranch(lineEndsBranch), .lineFallThrough(lineFallThrough),
    .lineTarget(lineTarget), .lineInsns(lineInsns)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [31:0]  startPc;
    int           len;
    logic [1:0]   flags;
    int           br;
    logic         endsBr;
    logic [31:0]  fall;
    logic [31:0]  tgt;
    logic [511:0] insns;
    string        tag;
  } lineT;

  lineT expQ[$];
  int   total = 0;
  int   failCount = 0;
  bit   done = 1'b0;

  // Reference model state, kept from the requirements.
  int           mMode = 0;  // 0 idle, 1 hunting, 2 building
  logic [31:0]  mHunt = '0;
  int           mCnt = 0;
  int           mBr = 0;
  logic [1:0]   mFlags = '0;
  logic [31:0]  mStart = '0;
  logic [31:0]  mTgt = '0;
  logic [511:0] mInsns = '0;
  string        curTag = "R4";

  task automatic check(input bit ok, input string req, input string act, input string exp);
    total++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  task automatic clearModel();
    mCnt = 0; mBr = 0; mFlags = '0; mTgt = '0; mInsns = '0;
  endtask

  function automatic logic [31:0] wordOf(input logic [31:0] pc);
    return pc ^ 32'hA5A5_0000;
  endfunction

  task automatic beat(input logic [31:0] pc, input logic [2:0] kind,
                      input logic taken, input logic [31:0] tgt);
    bit isBr;
    lineT e;
    @(negedge clk);
    inValid = 1'b1; inPc = pc; inInsn = wordOf(pc); inKind = kind;
    inTaken = taken; inTarget = tgt;
    @(posedge clk);
    #1;
    inValid = 1'b0;
    if (mMode == 0) return;
    if (mMode == 1 && pc != mHunt) return;
    mMode = 2;
    if (mCnt == 0) mStart = pc;
    mInsns[mCnt*32 +: 32] = wordOf(pc);
    isBr = (kind >= 3'd1 && kind <= 3'd4);
    if (isBr) begin
      if (mBr < 2) mFlags[mBr] = (kind == 3'd1) ? taken : 1'b1;
      mBr++;
      mTgt = tgt;
    end
    mCnt++;
    if (mCnt == 16 || mBr == 3 || (kind >= 3'd3 && kind <= 3'd5)) begin
      e.startPc = mStart; e.len = mCnt; e.flags = mFlags; e.br = mBr;
      e.endsBr = isBr; e.fall = pc + 32'd4; e.tgt = mTgt; e.insns = mInsns;
      e.tag = curTag;
      expQ.push_back(e);
      clearModel();
    end
  endtask

  task automatic sendMiss(input logic [31:0] pc);
    @(negedge clk);
    missValid = 1'b1; missPc = pc;
    @(posedge clk);
    #1;
    missValid = 1'b0;
    mMode = 1; mHunt = pc; clearModel();
  endtask

  task automatic sendFlush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    #1;
    flush = 1'b0;
    mMode = 0; clearModel();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkDrained(input string req);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, req, $sformatf("%0d pending lines", expQ.size()), "0 pending lines");
  endtask

  // Monitor: compare each pulse with the oldest expected line.
  always @(negedge clk) begin
    if (rstN && lineValid && !done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10", $sformatf("line at 0x%0h", lineStartPc), "no line");
      end else begin
        lineT e;
        bit ok;
        e = expQ.pop_front();
        ok = (lineStartPc == e.startPc) && (int'(lineLength) == e.len) &&
             (lineFlags == e.flags) && (int'(lineBranchCount) == e.br) &&
             (lineEndsBranch == e.endsBr) && (lineFallThrough == e.fall) &&
             (lineTarget == e.tgt);
        for (int s = 0; s < 16; s++)
          if (s < e.len && lineInsns[s*32 +: 32] != e.insns[s*32 +: 32]) ok = 1'b0;
        check(ok, e.tag,
          $sformatf("start=%h len=%0d flags=%b br=%0d end=%b fall=%h tgt=%h",
            lineStartPc, lineLength, lineFlags, lineBranchCount, lineEndsBranch,
            lineFallThrough, lineTarget),
          $sformatf("start=%h len=%0d flags=%b br=%0d end=%b fall=%h tgt=%h",
            e.startPc, e.len, e.flags, e.br, e.endsBr, e.fall, e.tgt));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failCount, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    @(negedge clk);
    check(lineValid == 1'b0 && lineLength == '0, "R8",
          $sformatf("valid=%b len=%0d", lineValid, lineLength), "valid=0 len=0");

    // R8: idle builder ignores beats.
    beat(32'h50, 3'd3, 1'b0, 32'h0);
    beat(32'h54, 3'd0, 1'b0, 32'h0);
    checkDrained("R8");

    // R2: hunt, then a line closed by its third branch.
    sendMiss(32'h100);
    curTag = "R2";
    beat(32'hF0, 3'd3, 1'b0, 32'h0);
    beat(32'h100, 3'd0, 1'b0, 32'h0);
    beat(32'h104, 3'd0, 1'b0, 32'h0);
    beat(32'h108, 3'd1, 1'b0, 32'h180);
    beat(32'h10C, 3'd0, 1'b0, 32'h0);
    beat(32'h110, 3'd1, 1'b1, 32'h200);
    beat(32'h200, 3'd0, 1'b0, 32'h0);
    beat(32'h204, 3'd2, 1'b0, 32'h300);
    // R1: the very next beat opens a 16-instruction line.
    curTag = "R1";
    for (int i = 0; i < 16; i++) beat(32'h300 + 32'(i*4), 3'd0, 1'b0, 32'h0);
    idle(2);

    // R3: return, system call and indirect endings.
    curTag = "R3";
    beat(32'h400, 3'd1, 1'b1, 32'h500);
    beat(32'h500, 3'd0, 1'b0, 32'h0);
    beat(32'h504, 3'd3, 1'b0, 32'h600);
    beat(32'h600, 3'd5, 1'b0, 32'h0);
    curTag = "R5";
    beat(32'h700, 3'd1, 1'b0, 32'h800);
    beat(32'h704, 3'd4, 1'b0, 32'h900);
    // R6: three not-taken conditionals.
    curTag = "R6";
    beat(32'hA00, 3'd1, 1'b0, 32'hB00);
    beat(32'hA04, 3'd1, 1'b0, 32'hB04);
    beat(32'hA08, 3'd1, 1'b0, 32'hB08);
    // R7: jump then plain instructions, ends by count.
    curTag = "R7";
    beat(32'hC00, 3'd2, 1'b0, 32'hD00);
    for (int i = 0; i < 15; i++) beat(32'hD00 + 32'(i*4), 3'd0, 1'b0, 32'h0);
    checkDrained("R7");

    // R9: flush discards the partial line and disarms.
    curTag = "R9";
    beat(32'hE00, 3'd0, 1'b0, 32'h0);
    beat(32'hE04, 3'd1, 1'b1, 32'hE40);
    sendFlush();
    beat(32'hE40, 3'd3, 1'b0, 32'h0);
    checkDrained("R9");

    // R8: a miss mid-line restarts the hunt.
    curTag = "R8";
    sendMiss(32'hF00);
    beat(32'hF00, 3'd0, 1'b0, 32'h0);
    beat(32'hF04, 3'd0, 1'b0, 32'h0);
    sendMiss(32'hF10);
    beat(32'hF08, 3'd3, 1'b0, 32'h0);
    beat(32'hF10, 3'd3, 1'b0, 32'hF80);
    checkDrained("R8");

    // R10: back-to-back finishing beats.
    curTag = "R10";
    beat(32'h1000, 3'd3, 1'b0, 32'h2000);
    beat(32'h1004, 3'd4, 1'b0, 32'h3000);
    beat(32'h1008, 3'd5, 1'b0, 32'h0);
    // R4: short plain line closed by a system call.
    curTag = "R4";
    beat(32'h1100, 3'd7, 1'b0, 32'h0);
    beat(32'h1104, 3'd6, 1'b0, 32'h0);
    beat(32'h1108, 3'd5, 1'b0, 32'h0);
    checkDrained("R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failCount, total);
    $finish;
  end

endmodule